// File: doc/BRIEF.md
# Programmable Microcoded Port Control Sequencer

This block is the control engine of a storage host port. Its control flow lives in a small program memory that software fills at run time. Each cycle the sequencer executes the word at its program counter. A word either fires a set of one-cycle action strobes toward the port datapath, branches when a selected condition flag is true, or branches always. Hardware events override the program flow. Power-on reset, controller reset, port reset, a device COMINIT and a software clear of the run bit each force the counter to a fixed entry address. A typical program uses a waiting loop that tests its condition flags one word at a time in a fixed order.

Software loads the program through a single 32-bit register write port. A select bit in the written value marks the write as either a load-address write or a data-word write. Data words go to consecutive addresses. Once a load address has been written, the sequencer parks at address 0 and stays silent until the next power-on reset releases it. The program memory keeps its contents across that reset.

Program word layout (18 bits): bits 17:16 hold the opcode (00 action, 01 conditional jump, 10 jump, 11 reserved). In jumps, bits 15:10 select a condition and bits 9:0 hold the target. In actions, bits 15:0 are the action mask. Action mask bits and `act_o` bits are: 0 port engine started, 1 clear issue slot 0, 2 clear busy and set data-request, 3 status := 0x7F, 4 status := 0x80, 5 arm signature update, 6 fetch signature, 7 go offline, 8 DMA abort, 9 clear command-running, 10 set command-running, 11 clear transfer counter, 15:12 spare.

Top module: `uctl_sequencer`

## Requirements
- R1: A register write with bit 24 = 1 sets the load address to bits PC_W-1:0 of the value. A write with bit 24 = 0 stores bits 17:0 as a program word. Bits 31:25 and 23:18 have no effect.
- R2: Each data write stores its word at the current load address and then advances the load address by one. Consecutive data writes therefore fill consecutive words.
- R3: From the second clock after an address write until the next power-on reset, the program counter stays at 0 and `act_o` stays 0, whatever the event and condition inputs do.
- R4: While `por` is high, `act_o` is 0, the counter is 0 and the load hold is released. Program memory keeps its contents, and execution restarts at address 0 once `por` falls.
- R5: A controller reset event vectors the counter to 2, a port reset to 4, COMINIT to 6 and run-cleared to 8. The entry word executes on the following clock.
- R6: Entry priority is power-on reset, then controller reset, then port reset, then COMINIT, then run-cleared.
- R7: An action word (opcode 00) drives its 16-bit mask on `act_o` for exactly one cycle: the cycle after the word is at the counter. Execution then falls through to the next address.
- R8: A conditional jump (opcode 01) loads the target when `cond_i[sel]` is 1 and otherwise falls through. A selector at or above NUM_COND reads as false. `cond_i` bits are: 0 detect field changed to 4, 1 changed to 1, 2 running with busy and data-request clear, 3 device register FIS (type 0x34) received.
- R9: An unconditional jump (opcode 10) always loads its target and raises no action.
- R10: A reserved word (opcode 11) raises no action and falls through.
- R11: In a cycle where an event vectors the counter, the word at the counter is abandoned and its actions are not issued.
- R12: Fall-through past the last address wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; also vectors to 0 |
| ev_ctl_rst | input | 1 | Controller reset event |
| ev_port_rst | input | 1 | Port reset event |
| ev_cominit | input | 1 | Device COMINIT event |
| ev_run_cleared | input | 1 | Software cleared the run bit |
| cond_i | input | NUM_COND | Condition flags |
| reg_we | input | 1 | Loader register write strobe |
| reg_wdata | input | 32 | Loader register write value |
| act_o | output | 16 | Registered one-cycle action strobes |

## Verification
On every cycle, the in-line properties check the following. The loader strobes follow each register write. Data strobes advance the load address, and each one lands in the program memory. A held sequencer sits at address 0 with no actions. Each event reaches its entry address in priority order. Action words copy their mask, unconditional jumps load their target, and reserved words step by one. The behaviour seen only through `act_o` needs the directed scenarios. These cover which bits of a register write are ignored, the order in which the waiting loop tests its flags, the suppression of an abandoned word's action, wrap-around past the last word, and whether the program survives a power-on reset.

// File: rtl/uctl_pkg.sv
package uctl_pkg;

   localparam int REG_W      = 32;
   localparam int WORD_W     = 18;
   localparam int MASK_W     = 16;
   localparam int CSEL_W     = 6;
   localparam int CSEL_LSB   = 10;
   localparam int TGT_W      = 10;
   localparam int NSEL       = 1 << CSEL_W;
   localparam int LD_SEL_BIT = 24;

   // fixed entry addresses
   localparam int VEC_POR     = 0;
   localparam int VEC_CTL     = 2;
   localparam int VEC_PORT    = 4;
   localparam int VEC_COMINIT = 6;
   localparam int VEC_RUNCLR  = 8;

   typedef enum logic [1:0] {
      OP_ACT  = 2'b00,
      OP_CJMP = 2'b01,
      OP_JMP  = 2'b10,
      OP_RSV  = 2'b11
   } op_e;

   typedef struct packed {
      op_e               op;
      logic [MASK_W-1:0] body;
   } word_t;

endpackage

// File: rtl/uctl_loader.sv
module uctl_loader
   import uctl_pkg::*;
#(
   parameter int PC_W = 8
) (
   input  logic              clk,
   input  logic              por,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic              mem_we,
   output logic [PC_W-1:0]   mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              hold_o
);

   logic              strb_a_q;
   logic              strb_d_q;
   logic [WORD_W-1:0] pay_q;
   logic [PC_W-1:0]   ld_addr_q;
   logic              hold_q;
   logic              unused_hi;

   // bits outside the payload and the select bit carry nothing
   assign unused_hi = ^{wr_data[REG_W-1:LD_SEL_BIT+1], wr_data[LD_SEL_BIT-1:WORD_W]};

   always_ff @(posedge clk) begin
      if (por) begin
         strb_a_q  <= 1'b0;
         strb_d_q  <= 1'b0;
         pay_q     <= '0;
         ld_addr_q <= '0;
         hold_q    <= 1'b0;
      end else begin
         strb_a_q <= wr_en &&  wr_data[LD_SEL_BIT];
         strb_d_q <= wr_en && !wr_data[LD_SEL_BIT];
         if (wr_en) pay_q <= wr_data[WORD_W-1:0];
         if (strb_a_q) begin
            ld_addr_q <= pay_q[PC_W-1:0];
            hold_q    <= 1'b1;
         end else if (strb_d_q) begin
            ld_addr_q <= ld_addr_q + PC_W'(1);
         end
      end
   end

   assign mem_we    = strb_d_q;
   assign mem_addr  = ld_addr_q;
   assign mem_wdata = pay_q;
   assign hold_o    = hold_q;

   a_r1_strobe_follows_write: assert property (@(posedge clk) disable iff (por)
      wr_en |=> (strb_a_q ^ strb_d_q));

   a_r1_no_strobe_without_write: assert property (@(posedge clk) disable iff (por)
      !wr_en |=> !(strb_a_q || strb_d_q));

   a_r2_addr_advance: assert property (@(posedge clk) disable iff (por)
      strb_d_q |=> (ld_addr_q == $past(ld_addr_q) + PC_W'(1)));

   a_r3_hold_sticky: assert property (@(posedge clk) disable iff (por)
      hold_q |=> hold_q);

endmodule

// File: rtl/uctl_pmem.sv
module uctl_pmem
   import uctl_pkg::*;
#(
   parameter int PC_W = 8
) (
   input  logic              clk,
   input  logic              por,
   input  logic              we,
   input  logic [PC_W-1:0]   waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [PC_W-1:0]   raddr,
   output logic [WORD_W-1:0] rdata
);

   localparam int DEPTH = 1 << PC_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

   a_r2_word_lands: assert property (@(posedge clk) disable iff (por)
      we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/uctl_evsel.sv
module uctl_evsel
   import uctl_pkg::*;
#(
   parameter int PC_W = 8
) (
   input  logic            ev_ctl_i,
   input  logic            ev_port_i,
   input  logic            ev_cominit_i,
   input  logic            ev_runclr_i,
   output logic            fire_o,
   output logic [PC_W-1:0] vec_o
);

   // fixed priority: controller, port, COMINIT, run-cleared
   always_comb begin
      fire_o = 1'b1;
      vec_o  = '0;
      if (ev_ctl_i)          vec_o = PC_W'(VEC_CTL);
      else if (ev_port_i)    vec_o = PC_W'(VEC_PORT);
      else if (ev_cominit_i) vec_o = PC_W'(VEC_COMINIT);
      else if (ev_runclr_i)  vec_o = PC_W'(VEC_RUNCLR);
      else                   fire_o = 1'b0;
   end

endmodule

// File: rtl/uctl_core.sv
module uctl_core
   import uctl_pkg::*;
#(
   parameter int PC_W     = 8,
   parameter int NUM_COND = 4
) (
   input  logic                clk,
   input  logic                por,
   input  logic                hold_i,
   input  logic                ev_ctl_i,
   input  logic                ev_port_i,
   input  logic                ev_cominit_i,
   input  logic                ev_runclr_i,
   input  logic [NUM_COND-1:0] cond_i,
   input  word_t               word_i,
   output logic [PC_W-1:0]     pc_o,
   output logic [MASK_W-1:0]   act_o
);

   logic [PC_W-1:0]   pc_q, pc_d, pc_inc, tgt;
   logic [MASK_W-1:0] act_q, act_d;
   logic [NSEL-1:0]   cond_ext;
   logic [CSEL_W-1:0] csel;
   logic              cond_hit;
   logic              ev_fire;
   logic [PC_W-1:0]   ev_vec;

   uctl_evsel #(.PC_W(PC_W)) evsel_i (
      .ev_ctl_i     (ev_ctl_i),
      .ev_port_i    (ev_port_i),
      .ev_cominit_i (ev_cominit_i),
      .ev_runclr_i  (ev_runclr_i),
      .fire_o       (ev_fire),
      .vec_o        (ev_vec)
   );

   // selectors beyond the live flags read as false
   for (genvar g = 0; g < NSEL; g++) begin : g_cond
      if (g < NUM_COND) begin : g_live
         assign cond_ext[g] = cond_i[g];
      end else begin : g_dead
         assign cond_ext[g] = 1'b0;
      end
   end

   assign csel     = word_i.body[CSEL_LSB +: CSEL_W];
   assign cond_hit = cond_ext[csel];
   assign tgt      = word_i.body[PC_W-1:0];
   assign pc_inc   = pc_q + PC_W'(1);

   always_comb begin
      pc_d  = pc_inc;
      act_d = '0;
      if (hold_i) begin
         pc_d = '0;
      end else if (ev_fire) begin
         pc_d = ev_vec;
      end else begin
         unique case (word_i.op)
            OP_ACT:  act_d = word_i.body;
            OP_CJMP: if (cond_hit) pc_d = tgt;
            OP_JMP:  pc_d = tgt;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (por) begin
         pc_q  <= PC_W'(VEC_POR);
         act_q <= '0;
      end else begin
         pc_q  <= pc_d;
         act_q <= act_d;
      end
   end

   assign pc_o  = pc_q;
   assign act_o = act_q;

   logic no_ev;
   assign no_ev = !(ev_ctl_i || ev_port_i || ev_cominit_i || ev_runclr_i);

   a_r3_hold_parks: assert property (@(posedge clk) disable iff (por)
      hold_i |=> (pc_q == '0 && act_q == '0));

   a_r5_ctl_entry: assert property (@(posedge clk) disable iff (por)
      (!hold_i && ev_ctl_i) |=> (pc_q == PC_W'(VEC_CTL) && act_q == '0));

   a_r6_port_over_cominit: assert property (@(posedge clk) disable iff (por)
      (!hold_i && !ev_ctl_i && ev_port_i) |=> (pc_q == PC_W'(VEC_PORT)));

   a_r6_cominit_over_runclr: assert property (@(posedge clk) disable iff (por)
      (!hold_i && !ev_ctl_i && !ev_port_i && ev_cominit_i) |=> (pc_q == PC_W'(VEC_COMINIT)));

   a_r5_runclr_entry: assert property (@(posedge clk) disable iff (por)
      (!hold_i && !ev_ctl_i && !ev_port_i && !ev_cominit_i && ev_runclr_i)
      |=> (pc_q == PC_W'(VEC_RUNCLR)));

   a_r7_action_copy: assert property (@(posedge clk) disable iff (por)
      (!hold_i && no_ev && word_i.op == OP_ACT)
      |=> (act_q == $past(word_i.body) && pc_q == $past(pc_q) + PC_W'(1)));

   a_r9_jump_target: assert property (@(posedge clk) disable iff (por)
      (!hold_i && no_ev && word_i.op == OP_JMP)
      |=> (pc_q == $past(word_i.body[PC_W-1:0]) && act_q == '0));

   a_r10_reserved_step: assert property (@(posedge clk) disable iff (por)
      (!hold_i && no_ev && word_i.op == OP_RSV)
      |=> (pc_q == $past(pc_q) + PC_W'(1) && act_q == '0));

endmodule

// File: rtl/uctl_sequencer.sv
module uctl_sequencer
   import uctl_pkg::*;
#(
   parameter int PC_W     = 8,
   parameter int NUM_COND = 4
) (
   input  logic                clk,
   input  logic                por,
   input  logic                ev_ctl_rst,
   input  logic                ev_port_rst,
   input  logic                ev_cominit,
   input  logic                ev_run_cleared,
   input  logic [NUM_COND-1:0] cond_i,
   input  logic                reg_we,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [MASK_W-1:0]   act_o
);

   if (PC_W < 4 || PC_W > TGT_W) begin : g_bad_pc
      $error("uctl_sequencer: PC_W must lie in 4..%0d", TGT_W);
   end
   if (NUM_COND < 1 || NUM_COND > NSEL) begin : g_bad_cond
      $error("uctl_sequencer: NUM_COND must lie in 1..%0d", NSEL);
   end

   logic              ld_we;
   logic [PC_W-1:0]   ld_addr;
   logic [WORD_W-1:0] ld_data;
   logic              ld_hold;
   logic [PC_W-1:0]   pc;
   logic [WORD_W-1:0] rd_word;

   uctl_loader #(.PC_W(PC_W)) loader_i (
      .clk       (clk),
      .por       (por),
      .wr_en     (reg_we),
      .wr_data   (reg_wdata),
      .mem_we    (ld_we),
      .mem_addr  (ld_addr),
      .mem_wdata (ld_data),
      .hold_o    (ld_hold)
   );

   uctl_pmem #(.PC_W(PC_W)) pmem_i (
      .clk   (clk),
      .por   (por),
      .we    (ld_we),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (pc),
      .rdata (rd_word)
   );

   uctl_core #(.PC_W(PC_W), .NUM_COND(NUM_COND)) core_i (
      .clk          (clk),
      .por          (por),
      .hold_i       (ld_hold),
      .ev_ctl_i     (ev_ctl_rst),
      .ev_port_i    (ev_port_rst),
      .ev_cominit_i (ev_cominit),
      .ev_runclr_i  (ev_run_cleared),
      .cond_i       (cond_i),
      .word_i       (word_t'(rd_word)),
      .pc_o         (pc),
      .act_o        (act_o)
   );

endmodule

// File: tb/uctl_sequencer_tb_top.sv
module uctl_sequencer_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        por = 1'b1;
   logic        ev_ctl_rst = 1'b0, ev_port_rst = 1'b0, ev_cominit = 1'b0, ev_run_cleared = 1'b0;
   logic [3:0]  cond_i = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [15:0] act_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uctl_sequencer dut_i (
      .clk(clk), .por(por), .ev_ctl_rst(ev_ctl_rst), .ev_port_rst(ev_port_rst),
      .ev_cominit(ev_cominit), .ev_run_cleared(ev_run_cleared), .cond_i(cond_i),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .act_o(act_o)
   );

   function automatic logic [17:0] w_act(input logic [15:0] m);
      return {2'b00, m};
   endfunction
   function automatic logic [17:0] w_cj(input logic [5:0] s, input logic [9:0] t);
      return {2'b01, s, t};
   endfunction
   function automatic logic [17:0] w_jmp(input logic [9:0] t);
      return {2'b10, 6'd0, t};
   endfunction

   // test program; the wait loop is 0x12..0x18
   function automatic logic [17:0] prog_word(input int a);
      case (a)
         8'h00: return w_jmp(10'h10);
         8'h02: return w_act(16'h0008);
         8'h03: return w_jmp(10'h12);
         8'h04: return w_act(16'h0010);
         8'h05: return w_jmp(10'h12);
         8'h06: return w_act(16'h0020);
         8'h07: return w_jmp(10'h12);
         8'h08: return w_act(16'h0040);
         8'h09: return w_jmp(10'h12);
         8'h10: return w_act(16'h0001);
         8'h11: return w_act(16'h0006);
         8'h12: return w_cj(6'd0, 10'h60);
         8'h13: return w_cj(6'd1, 10'h68);
         8'h14: return w_cj(6'd2, 10'h70);
         8'h15: return w_cj(6'd3, 10'h78);
         8'h16: return w_cj(6'd63, 10'h7F);
         8'h17: return 18'h3FFFF;
         8'h18: return w_jmp(10'h12);
         8'h60: return w_act(16'h0080);
         8'h61: return w_jmp(10'h12);
         8'h68: return w_act(16'h0100);
         8'h69: return w_jmp(10'h12);
         8'h70: return w_act(16'h0200);
         8'h71: return w_jmp(10'h12);
         8'h78: return w_act(16'h0400);
         8'h79: return w_jmp(10'hFE);
         8'h7F: return w_act(16'h8000);
         8'h80: return w_jmp(10'h12);
         8'hFE: return w_act(16'h0800);
         8'hFF: return w_act(16'h1000);
         default: return 18'h0;
      endcase
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] exp);
      checks++;
      if (act_o !== exp) begin
         errors++;
         $display("FAIL %s: act_o=%h expected %h", tag, act_o, exp);
      end
   endtask

   task automatic wr_reg(input logic [31:0] d);
      reg_wdata = d;
      reg_we    = 1'b1;
      step();
      reg_we    = 1'b0;
   endtask

   task automatic expect_next(input logic [15:0] exp, input string tag);
      for (int i = 0; i < 24; i++) begin
         step();
         if (act_o != 16'h0) break;
      end
      chk(tag, exp);
   endtask

   task automatic quiet(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         step();
         chk(tag, 16'h0);
      end
   endtask

   task automatic set_ev(input logic [3:0] e);
      {ev_ctl_rst, ev_port_rst, ev_cominit, ev_run_cleared} = e;
   endtask

   // power-on pulse with optional coincident events, then boot checks
   task automatic por_boot(input logic [3:0] e, input string tag);
      por = 1'b1;
      set_ev(e);
      step();
      set_ev(4'b0);
      step();
      chk({tag, " R4 act low in reset"}, 16'h0);
      por = 1'b0;
      step();
      chk({tag, " R4/R9 jump at 0"}, 16'h0);
      step();
      chk({tag, " R7 first word"}, 16'h0001);
      step();
      chk({tag, " R7 multi-hot"}, 16'h0006);
      step();
      chk({tag, " R7 one cycle"}, 16'h0000);
   endtask

   task automatic ev_test(input logic [3:0] e, input logic [15:0] exp, input string tag);
      set_ev(e);
      step();
      set_ev(4'b0);
      chk({tag, " vector cycle"}, 16'h0);
      step();
      chk({tag, " entry action"}, exp);
      step();
      chk({tag, " back to loop"}, 16'h0);
   endtask

   task automatic t_load();
      wr_reg(32'h0100_0000);
      for (int a = 0; a < 256; a++) wr_reg({14'h0, prog_word(a)});
      por_boot(4'b0, "boot");
      quiet(20, "R10/R8 idle loop silent");
   endtask

   task automatic t_events();
      ev_test(4'b1000, 16'h0008, "R5 ctl");
      ev_test(4'b0100, 16'h0010, "R5 port");
      ev_test(4'b0010, 16'h0020, "R5 cominit");
      ev_test(4'b0001, 16'h0040, "R5 runclr");
   endtask

   task automatic t_priority();
      ev_test(4'b1111, 16'h0008, "R6 ctl first");
      ev_test(4'b0111, 16'h0010, "R6 port next");
      ev_test(4'b0011, 16'h0020, "R6 cominit next");
      por_boot(4'b1111, "R6 por wins");
   endtask

   task automatic t_suppress();
      por = 1'b1;
      step();
      step();
      por = 1'b0;
      step();
      chk("R11 jump at 0", 16'h0);
      set_ev(4'b0001);
      step();
      set_ev(4'b0);
      chk("R11 abandoned word silent", 16'h0);
      step();
      chk("R11 entry runs", 16'h0040);
      step();
      chk("R11 after entry", 16'h0);
   endtask

   task automatic t_conds();
      cond_i = 4'b0001;
      expect_next(16'h0080, "R8 cond0 taken");
      cond_i = 4'b0;
      quiet(10, "R8 cond0 done");
      cond_i = 4'b0010;
      expect_next(16'h0100, "R8 cond1 taken");
      cond_i = 4'b0;
      quiet(10, "R8 cond1 done");
      cond_i = 4'b0100;
      expect_next(16'h0200, "R8 cond2 taken");
      cond_i = 4'b0;
      quiet(10, "R8 cond2 done");
      // ordered tests, synchronised through the controller entry
      cond_i = 4'b1001;
      set_ev(4'b1000);
      step();
      set_ev(4'b0);
      step();
      chk("R8 order sync", 16'h0008);
      expect_next(16'h0080, "R8 order cond0 before cond3");
      cond_i = 4'b0;
      quiet(10, "R8 order done");
      cond_i = 4'b0110;
      set_ev(4'b1000);
      step();
      set_ev(4'b0);
      step();
      chk("R8 order sync 2", 16'h0008);
      expect_next(16'h0100, "R8 order cond1 before cond2");
      cond_i = 4'b0;
      quiet(10, "R8 order 2 done");
   endtask

   task automatic t_wrap();
      cond_i = 4'b1000;
      set_ev(4'b1000);
      step();
      set_ev(4'b0);
      expect_next(16'h0008, "R12 sync");
      expect_next(16'h0400, "R8 cond3 taken");
      cond_i = 4'b0;
      step();
      chk("R9 jump silent", 16'h0);
      step();
      chk("R12 word 0xFE", 16'h0800);
      step();
      chk("R12 word 0xFF", 16'h1000);
      step();
      chk("R12 wrapped to 0", 16'h0);
      step();
      chk("R12 word 0x10", 16'h0001);
      step();
      chk("R12 word 0x11", 16'h0006);
      quiet(10, "R12 settle");
   endtask

   task automatic t_reload();
      // address write to 2 with junk in the ignored bits
      wr_reg(32'hFFFC_0002);
      step();
      cond_i = 4'hF;
      set_ev(4'b1111);
      quiet(3, "R3 held under events");
      set_ev(4'b0);
      quiet(15, "R3 held under conditions");
      cond_i = 4'b0;
      wr_reg(32'hFEFC_2000);
      wr_reg(32'hFEFE_0060);
      chk("R3 held while loading", 16'h0);
      quiet(4, "R3 still held");
      por_boot(4'b0, "R4 program kept");
      ev_test(4'b1000, 16'h2000, "R1 payload only");
      step();
      chk("R2 next word went to 3", 16'h0080);
      step();
      chk("R2 loop resumes", 16'h0);
   endtask

   initial begin
      repeat (3) step();
      chk("R4 reset state", 16'h0);
      por = 1'b0;
      step();
      t_load();
      t_events();
      t_priority();
      t_suppress();
      t_conds();
      t_wrap();
      t_reload();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: act_o=%h expected completion", act_o);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule